// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is a watchdog timer with a reset-control front end, reached through a small register bus with a single-cycle write strobe and a combinational read port. Three 32-bit registers are visible: a control register holding a two-bit expiry configuration, a status register holding reset-cause flags, and a timer register holding a 20-bit countdown. Every write must carry the unlock key 0x5A in bits 31:24. A write with any other key changes nothing and raises a one-cycle key error.

The countdown advances once per pulse of a tick enable. When it runs out while the configuration selects full reset, the block drives its system reset output for a fixed number of clock cycles. It also sets the full-watchdog-reset flag in the status register and returns the configuration to zero. Software forces a quick reboot by loading a short count, for example 10 ticks, and then selecting full reset.

The sequencing is a three-state machine. IDLE means the count is zero and nothing runs. RUN means a nonzero count is being decremented. FIRE means the reset pulse is being driven. The transitions are:
- LOAD: IDLE to RUN, when a keyed write loads a nonzero count.
- CLEAR: RUN to IDLE, when a keyed write loads zero.
- LAPSE: RUN to IDLE, when the count reaches zero and the configuration is not full reset.
- EXPIRE: RUN to FIRE, when the count reaches zero and the configuration is full reset.
- RELEASE: FIRE back to RUN or IDLE after the pulse, chosen by whether the count is then nonzero.

Top module: `wdog_rstctl`

## Requirements
- R1: After reset, the status register reads 0x0000_1000 (bit 12, power-on flag). The control and timer registers read 0. `sys_rst_out` and `key_err` are low.
- R2: A write takes effect only when `bus_wdata[31:24]` is 0x5A. Offsets are 0x1C for control, 0x20 for status and 0x24 for timer. A keyed write to any other offset has no effect and raises no error. Every read returns 0 in bits 31:24.
- R3: A write whose bits 31:24 are not 0x5A leaves all three registers unchanged. It drives `key_err` high for exactly the one cycle after the write edge.
- R4: A keyed write to the timer register loads `bus_wdata[19:0]` as the count. Reading the timer register returns the remaining count in bits 19:0 and zeros above.
- R5: The count decreases by one on each clock edge where `tick_en` is high and the count is nonzero. Without a tick, or at zero, it holds.
- R6: When a tick takes the count from 1 to 0 while the configuration field (control bits 5:4) is 2'b10, `sys_rst_out` is high for exactly 4 cycles starting the next cycle. Status bit 5 is set and the configuration field reads 00. While `sys_rst_out` is high the count does not decrement.
- R7: When the count reaches zero with a configuration other than 2'b10, no reset pulse occurs, the count stays 0 and the status register is unchanged.
- R8: A keyed write to the status register clears each flag whose data bit is 1. Only bits 0, 1, 2, 4, 5, 6, 8, 9, 10 and 12 can ever read as 1.
- R9: The control register stores only bits 5:4. All its other bits read 0.
- R10: A keyed timer write in the same cycle as a tick loads the written value and neither decrements nor expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data, key in bits 31:24 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tick_en | input | 1 | Countdown tick enable |
| sys_rst_out | output | 1 | System reset pulse on full-reset expiry |
| key_err | output | 1 | One-cycle pulse after a write with a wrong key |

## Verification
Directed sequences cover the following cases:
- the quick-reboot pattern, which separates a correct 4-cycle pulse with its status and configuration side effects from a lapse without reset;
- wrong-key writes aimed at each register, which show that rejection touches nothing;
- a load coinciding with a tick, which exposes the priority between load and decrement;
- writing all ones to the status and control registers, which shows which bit positions can be stored.

A long seeded random mix of keyed and unkeyed writes, stray offsets, short loads and random ticks is compared every cycle against a bench model. This catches ordering faults between expiry, configuration writes and status clears, including writes that land during the reset pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [7:0]  WD_KEY        = 8'h5A;
    localparam logic [7:0]  OFF_CTRL      = 8'h1C;
    localparam logic [7:0]  OFF_STAT      = 8'h20;
    localparam logic [7:0]  OFF_TIMER     = 8'h24;
    localparam logic [1:0]  CFG_FULL      = 2'b10;
    localparam logic [31:0] STAT_MASK     = 32'h0000_1777;
    localparam int          STAT_POR_BIT  = 12;
    localparam int          STAT_WDF_BIT  = 5;
    localparam int          CFG_LSB       = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdog_bus_gate.sv
module wdog_bus_gate
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              wr_ctrl,
    output logic              wr_stat,
    output logic              wr_timer,
    output logic              key_err
);

    localparam int KEY_LSB = DATA_W - 8;

    logic key_match;
    logic key_bad;

    // Key check is on the top byte of the write data.
    assign key_match = (bus_wdata[DATA_W-1:KEY_LSB] == WD_KEY);
    assign key_bad   = bus_we && !key_match;

    always_comb begin
        wr_ctrl  = 1'b0;
        wr_stat  = 1'b0;
        wr_timer = 1'b0;
        if (bus_we && key_match) begin
            wr_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
            wr_stat  = (bus_addr == ADDR_W'(OFF_STAT));
            wr_timer = (bus_addr == ADDR_W'(OFF_TIMER));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_err <= 1'b0;
        else        key_err <= key_bad;
    end

endmodule

// File: rtl/wdog_timer_fsm.sv
module wdog_timer_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 20,
    parameter int PULSE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cfg_full,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire,
    output logic             rst_pulse
);

    localparam int FW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [FW-1:0] FIRE_LAST = FW'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    wd_state_e        state_q, state_d;
    logic [FW-1:0]    fire_q;
    logic [CNT_W-1:0] cnt_d;
    logic             dec;
    logic             fire_last;

    // A decrement happens only in RUN and only on a tick; a load wins.
    assign dec       = (state_q == ST_RUN) && tick_en && !load;
    assign expire    = dec && (cnt_q == CNT_ONE) && cfg_full;
    assign fire_last = (fire_q == FIRE_LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (load)     cnt_d = load_val;
        else if (dec) cnt_d = cnt_q - CNT_ONE;
    end

    // Next-state logic: LOAD, CLEAR, LAPSE, EXPIRE, RELEASE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = (cnt_d != '0) ? ST_RUN : ST_IDLE;
            ST_RUN: begin
                if (expire)            state_d = ST_FIRE;
                else if (cnt_d != '0)  state_d = ST_RUN;
                else                   state_d = ST_IDLE;
            end
            ST_FIRE: begin
                if (!fire_last)        state_d = ST_FIRE;
                else if (cnt_d != '0)  state_d = ST_RUN;
                else                   state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            fire_q    <= '0;
            rst_pulse <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            rst_pulse <= (state_d == ST_FIRE);
            if (state_q == ST_FIRE) fire_q <= fire_q + FW'(1);
            else                    fire_q <= '0;
        end
    end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output logic [1:0]        cfg_q,
    output logic [DATA_W-1:0] stat_q
);

    localparam logic [DATA_W-1:0] POR_VAL  = DATA_W'(1) << STAT_POR_BIT;
    localparam logic [DATA_W-1:0] WDF_FLAG = DATA_W'(1) << STAT_WDF_BIT;
    localparam logic [DATA_W-1:0] MASK     = DATA_W'(STAT_MASK);

    logic [DATA_W-1:0] clr_bits;

    assign clr_bits = wr_stat ? (wdata & MASK) : '0;

    // Expiry overrides a configuration write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cfg_q <= 2'b00;
        else if (expire)  cfg_q <= 2'b00;
        else if (wr_ctrl) cfg_q <= wdata[CFG_LSB+1:CFG_LSB];
    end

    // Flags clear on a one; expiry sets its flag after clearing.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= POR_VAL;
        else        stat_q <= (stat_q & ~clr_bits) | (expire ? WDF_FLAG : '0);
    end

endmodule

// File: rtl/wdog_rstctl.sv
module wdog_rstctl
    import wdog_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CNT_W     = 20,
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_en,
    output logic              sys_rst_out,
    output logic              key_err
);

    localparam int DATA_W = 32;

    logic              wr_ctrl, wr_stat, wr_timer;
    logic              expire;
    logic [1:0]        cfg_q;
    logic [DATA_W-1:0] stat_q;
    logic [CNT_W-1:0]  cnt_q;

    wdog_bus_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .wr_ctrl  (wr_ctrl),
        .wr_stat  (wr_stat),
        .wr_timer (wr_timer),
        .key_err  (key_err)
    );

    wdog_timer_fsm #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (wr_timer),
        .load_val (bus_wdata[CNT_W-1:0]),
        .cfg_full (cfg_q == CFG_FULL),
        .cnt_q    (cnt_q),
        .expire   (expire),
        .rst_pulse(sys_rst_out)
    );

    wdog_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(wr_ctrl),
        .wr_stat(wr_stat),
        .wdata  (bus_wdata),
        .expire (expire),
        .cfg_q  (cfg_q),
        .stat_q (stat_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL))
            bus_rdata[CFG_LSB+1:CFG_LSB] = cfg_q;
        else if (bus_addr == ADDR_W'(OFF_STAT))
            bus_rdata = stat_q & STAT_MASK;
        else if (bus_addr == ADDR_W'(OFF_TIMER))
            bus_rdata[CNT_W-1:0] = cnt_q;
    end

endmodule

// File: rtl/wdog_rstctl_chk.sv
module wdog_rstctl_chk
    import wdog_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CNT_W     = 20,
    parameter int PULSE_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              tick_en,
    input logic              sys_rst_out,
    input logic              key_err,
    input logic [1:0]        cfg_q,
    input logic [31:0]       stat_q,
    input logic [CNT_W-1:0]  cnt_q
);

    logic   bad_wr;
    logic   timer_ld;
    logic [31:0] run_len;

    assign bad_wr   = bus_we && (bus_wdata[31:24] != WD_KEY);
    assign timer_ld = bus_we && (bus_wdata[31:24] == WD_KEY)
                      && (bus_addr == ADDR_W'(OFF_TIMER));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_len <= '0;
        else if (sys_rst_out) run_len <= run_len + 32'd1;
        else                  run_len <= '0;
    end

    assert_err_after_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> key_err);

    assert_no_err_on_good_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_wr |=> !key_err);

    assert_bad_keeps_regs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_wr && !tick_en) |=> ($stable(cfg_q) && $stable(stat_q)));

    assert_zero_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !timer_ld) |=> cnt_q == '0);

    assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !timer_ld && cnt_q != '0 && !sys_rst_out)
        |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_out) |-> run_len == PULSE_CYC);

    assert_expiry_effects_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_out) |-> (cfg_q == 2'b00 && stat_q[STAT_WDF_BIT]));

    assert_flag_positions_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~STAT_MASK) == 32'd0);

endmodule

bind wdog_rstctl wdog_rstctl_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .tick_en    (tick_en),
    .sys_rst_out(sys_rst_out),
    .key_err    (key_err),
    .cfg_q      (cfg_q),
    .stat_q     (stat_q),
    .cnt_q      (cnt_q)
);

// File: tb/wdog_rstctl_test.sv
module wdog_rstctl_test;

    localparam logic [7:0] A_CTRL  = 8'h1C;
    localparam logic [7:0] A_STAT  = 8'h20;
    localparam logic [7:0] A_TIMER = 8'h24;
    localparam logic [7:0] KEY     = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        sys_rst_out;
    logic        key_err;

    int checks = 0;
    int failures = 0;

    logic [19:0] m_cnt;
    logic [1:0]  m_cfg;
    logic [31:0] m_stat;
    int          m_fire;
    logic        m_err;

    always #10 clk = ~clk;

    wdog_rstctl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .sys_rst_out(sys_rst_out), .key_err(key_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_model(input logic [7:0] a);
        if (a == A_CTRL)  return {26'd0, m_cfg, 4'd0};
        if (a == A_STAT)  return m_stat;
        if (a == A_TIMER) return {12'd0, m_cnt};
        return 32'd0;
    endfunction

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic compare_all;
        logic [31:0] v;
        chk("R6 rst_out", {31'd0, sys_rst_out}, {31'd0, m_fire > 0});
        chk("R3 key_err", {31'd0, key_err}, {31'd0, m_err});
        rd(A_CTRL, v);  chk("R9 ctrl", v, rd_model(A_CTRL));
        rd(A_STAT, v);  chk("R8 stat", v, rd_model(A_STAT));
        rd(A_TIMER, v); chk("R5 timer", v, rd_model(A_TIMER));
    endtask

    // One clock: drive at negedge, model update at edge, compare at next negedge.
    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d, input logic tk);
        logic ok, ld, wc, ws, exp_now;
        logic [19:0] n_cnt;
        logic [1:0]  n_cfg;
        logic [31:0] n_stat;
        int          n_fire;
        bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk;
        ok = we && (d[31:24] == KEY);
        ld = ok && (a == A_TIMER);
        wc = ok && (a == A_CTRL);
        ws = ok && (a == A_STAT);
        exp_now = (m_fire == 0) && tk && !ld && (m_cnt == 20'd1) && (m_cfg == 2'b10);
        n_cnt = ld ? d[19:0] : ((m_fire == 0 && tk && m_cnt != 0) ? m_cnt - 20'd1 : m_cnt);
        n_cfg = exp_now ? 2'b00 : (wc ? d[5:4] : m_cfg);
        n_stat = (m_stat & ~(ws ? (d & 32'h1777) : 32'd0)) | (exp_now ? 32'h20 : 32'd0);
        n_fire = exp_now ? 4 : (m_fire > 0 ? m_fire - 1 : 0);
        @(posedge clk);
        m_cnt = n_cnt; m_cfg = n_cfg; m_stat = n_stat; m_fire = n_fire;
        m_err = we && !ok;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
        compare_all();
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        m_cnt = 0; m_cfg = 0; m_stat = 32'h1000; m_fire = 0; m_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(A_STAT, v);  chk("R1 status por", v, 32'h0000_1000);
        rd(A_CTRL, v);  chk("R1 ctrl zero", v, 32'h0);
        rd(A_TIMER, v); chk("R1 timer zero", v, 32'h0);
        chk("R1 outputs low", {30'd0, sys_rst_out, key_err}, 32'h0);

        // R2 / R4 keyed load, no tick
        step(1'b1, A_TIMER, 32'h5AF0_0010, 1'b0);
        rd(A_TIMER, v); chk("R4 load low 20 bits", v, 32'h10);
        // R2 keyed write to stray offset
        step(1'b1, 8'h28, 32'h5A00_0033, 1'b0);
        chk("R2 stray offset no error", {31'd0, key_err}, 32'h0);
        // R3 bad key on timer and ctrl
        step(1'b1, A_TIMER, 32'h1200_0005, 1'b0);
        chk("R3 err pulse", {31'd0, key_err}, 32'h1);
        rd(A_TIMER, v); chk("R3 timer unchanged", v, 32'h10);
        step(1'b0, A_CTRL, 32'h0, 1'b0);
        chk("R3 err one cycle", {31'd0, key_err}, 32'h0);
        step(1'b1, A_CTRL, 32'hA500_0020, 1'b0);
        rd(A_CTRL, v); chk("R3 ctrl unchanged", v, 32'h0);
        // R9 control keeps only bits 5:4; read top byte zero (R2)
        step(1'b1, A_CTRL, 32'h5AFF_FFCF, 1'b0);
        rd(A_CTRL, v); chk("R9 ctrl masked", v, 32'h0);
        step(1'b1, A_CTRL, 32'h5A00_0010, 1'b0);
        rd(A_CTRL, v); chk("R9 ctrl field", v, 32'h10);
        // R5 decrement per tick
        step(1'b0, 8'h00, 32'h0, 1'b1);
        step(1'b0, 8'h00, 32'h0, 1'b1);
        step(1'b0, 8'h00, 32'h0, 1'b0);
        rd(A_TIMER, v); chk("R5 two ticks", v, 32'h0E);
        // R10 load and tick together
        step(1'b1, A_TIMER, 32'h5A00_0003, 1'b1);
        rd(A_TIMER, v); chk("R10 load wins", v, 32'h3);
        // R7 lapse with cfg 01
        for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 32'h0, 1'b1);
        rd(A_TIMER, v); chk("R7 count zero", v, 32'h0);
        rd(A_STAT, v);  chk("R7 no flag", v, 32'h1000);
        chk("R7 no reset", {31'd0, sys_rst_out}, 32'h0);
        // R6 quick reboot: count 10 then full reset
        step(1'b1, A_TIMER, 32'h5A00_000A, 1'b0);
        step(1'b1, A_CTRL, 32'h5A00_0020, 1'b0);
        for (int i = 0; i < 9; i++) step(1'b0, 8'h00, 32'h0, 1'b1);
        chk("R6 not yet", {31'd0, sys_rst_out}, 32'h0);
        step(1'b0, 8'h00, 32'h0, 1'b1);
        chk("R6 pulse start", {31'd0, sys_rst_out}, 32'h1);
        rd(A_STAT, v); chk("R6 flag set", v, 32'h1020);
        rd(A_CTRL, v); chk("R6 cfg cleared", v, 32'h0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 8'h00, 32'h0, 1'b1);
            chk("R6 pulse held", {31'd0, sys_rst_out}, 32'h1);
        end
        step(1'b0, 8'h00, 32'h0, 1'b1);
        chk("R6 pulse ends", {31'd0, sys_rst_out}, 32'h0);
        // R8 write-one-to-clear
        step(1'b1, A_STAT, 32'h5A00_1000, 1'b0);
        rd(A_STAT, v); chk("R8 clear por", v, 32'h20);
        step(1'b1, A_STAT, 32'h5AFF_FFFF, 1'b0);
        rd(A_STAT, v); chk("R8 clear all", v, 32'h0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r, d;
            logic [7:0]  a;
            logic        we;
            r = $urandom;
            we = (r[3:0] < 4'd5);
            unique case (r[6:5])
                2'd0: a = A_CTRL;
                2'd1: a = A_STAT;
                2'd2: a = A_TIMER;
                default: a = 8'($urandom);
            endcase
            d = $urandom;
            if (a == A_TIMER) d[19:0] = 20'(d[4:0]);
            if (a == A_CTRL && r[9]) d[5:4] = 2'b10;
            if (r[12:10] != 3'd0) d[31:24] = KEY;
            step(we, a, d, r[16]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule